// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is the slave end of a two-wire serial bus (I2C-compatible, fast mode up to 400 kHz SCL). It turns bus transactions into single-byte accesses on an 8-bit register bank. It watches both bus lines through synchronisers and glitch filters, and it finds START and STOP conditions. It answers its own 7-bit device address and the general-call address. Both lines are open-drain: each output is an enable that pulls its line low.

A write transaction carries a register address byte and then any number of data bytes. Each data byte becomes one write strobe at the current pointer, and the pointer then advances. A read transaction, normally placed after a repeated START that follows a register address write, fetches one byte per strobe from the current pointer and shifts it out MSB first. The pointer advances after each fetch. The general-call reset command makes the block send a one-cycle reset pulse to the register bank. The bank side can ask the block to hold SCL low, but only in the slot just before an acknowledge bit that the slave drives.

Top module: `twi_reg_slave`

## Requirements
- R1: The device address is `1001` followed by the 3 bits of `addr_sel`. An address byte whose upper 7 bits match it is acknowledged, and bit 0 selects read (1) or write (0). Any other address byte except 0x00 gets no acknowledge. After such a byte, SDA stays released and no strobe occurs until the next START.
- R2: In a write transaction, the first byte after the address is acknowledged and loads the register pointer. Each later byte is acknowledged and gives exactly one `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one.
- R3: An acknowledged read address gives one `reg_re` pulse and sends the byte on `reg_rdata` MSB first. After each read byte, a master ACK (SDA low) gives the next `reg_re` pulse and sends the next byte. A master NACK ends the transfer with SDA released. The pointer advances by one after each `reg_re`.
- R4: Address byte 0x00 (general call) is acknowledged. A following command byte 0x06 is acknowledged and produces a one-cycle `bank_rst` pulse. Any other command byte gets no acknowledge and no pulse.
- R5: The block holds SCL low (`scl_oe`=1) only after the SCL falling edge that ends the 8th bit of a byte it acknowledges, and only while `stretch_req` is high. It releases SCL once `stretch_req` goes low. It never asserts `scl_oe` for a byte it does not acknowledge.
- R6: `sda_oe` changes only while SCL is low.
- R7: A pulse on SCL or SDA shorter than `FILT_CYC` clock cycles has no effect on the transfer.
- R8: A START (SDA falling while SCL high) restarts address reception from any state. A STOP (SDA rising while SCL high) returns the block to idle with both lines released. A partial byte cut off by a START or STOP produces no strobe.
- R9: After reset, `scl_oe`, `sda_oe`, `reg_we`, `reg_re` and `bank_rst` are 0.
- R10: At most one of `reg_we`, `reg_re` and `bank_rst` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| addr_sel | input | 3 | Low 3 bits of the device address |
| stretch_req | input | 1 | Bank asks for SCL to be held before an ACK |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at `reg_addr`, valid in the `reg_re` cycle |
| reg_re | output | 1 | One-cycle read strobe |
| bank_rst | output | 1 | One-cycle register bank reset pulse |

## Verification
A pin edge reaches the state machine about `FILT_CYC`+3 clocks after it appears on `scl_i` or `sda_i`. Each strobe, the SDA drive and the stretch request then follow within one or two more cycles. The bench model master holds each SCL half-period for 40 clocks, well above that latency. It reads SDA only halfway through an SCL-high phase and checks `scl_oe` 40 and 140 cycles after the 8th falling edge. The bank model and the pulse counters record strobes every cycle. The bench compares them only after the whole byte or transaction has completed, so no check depends on the exact filter latency.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int          BYTE_W       = 8;
    localparam int          SEL_W        = 3;
    localparam logic [3:0]  DEV_BASE     = 4'b1001;
    localparam logic [7:0]  GC_ADDR      = 8'h00;
    localparam logic [7:0]  GC_RESET_CMD = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_PREP,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MWAIT
    } twi_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_GC,
        K_REG,
        K_DATA
    } twi_kind_e;

    typedef struct packed {
        twi_state_e          state;
        twi_kind_e           kind;
        logic [BYTE_W-1:0]   sr;
        logic [BYTE_W-1:0]   tx;
        logic [3:0]          cnt;
        logic                ack;
        logic                rd;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   wdata;
        logic                we;
        logic                re;
        logic                rst;
        logic                scl_oe;
        logic                sda_oe;
    } twi_regs_t;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int W        = 2,
    parameter int FILT_CYC = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic          s1_q, s2_q, o_q;
        logic [CW-1:0] c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
                o_q  <= 1'b1;
                c_q  <= '0;
            end else begin
                s1_q <= pin_i[i];
                s2_q <= s1_q;
                if (s2_q != o_q) begin
                    if (c_q == CW'(FILT_CYC - 1)) begin
                        o_q <= s2_q;
                        c_q <= '0;
                    end else begin
                        c_q <= c_q + 1'b1;
                    end
                end else begin
                    c_q <= '0;
                end
            end
        end

        assign pin_o[i] = o_q;
    end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign start_o = scl_f & scl_p_q & sda_p_q & ~sda_f;
    assign stop_o  = scl_f & scl_p_q & ~sda_p_q & sda_f;
    assign rise_o  = scl_f & ~scl_p_q;
    assign fall_o  = ~scl_f & scl_p_q;
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter int FILT_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic              stretch_req,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              reg_re,
    output logic              bank_rst
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] FULL_CNT = 4'd8;

    logic [1:0] filt;
    logic       scl_f, sda_f;
    logic       ev_start, ev_stop, ev_rise, ev_fall;

    twi_glitch_filter #(.W(2), .FILT_CYC(FILT_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({scl_i, sda_i}),
        .pin_o (filt)
    );
    assign scl_f = filt[1];
    assign sda_f = filt[0];

    twi_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    twi_regs_t r_q, r_d;
    logic [6:0] own_addr;
    assign own_addr = {DEV_BASE, addr_sel};

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.re  = 1'b0;
        r_d.rst = 1'b0;

        // strobe done last cycle: fetch read data and advance pointer
        if (r_q.re) begin
            r_d.tx  = reg_rdata;
            r_d.ptr = r_q.ptr + 1'b1;
        end
        if (r_q.we) begin
            r_d.ptr = r_q.ptr + 1'b1;
        end

        if (ev_stop) begin
            r_d.state  = ST_IDLE;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end else if (ev_start) begin
            r_d.state  = ST_RX;
            r_d.kind   = K_ADDR;
            r_d.cnt    = '0;
            r_d.rd     = 1'b0;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: ;
                ST_RX: begin
                    if (ev_rise && r_q.cnt != FULL_CNT) begin
                        r_d.sr  = {r_q.sr[BYTE_W-2:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (ev_fall && r_q.cnt == FULL_CNT) begin
                        r_d.ack = 1'b0;
                        unique case (r_q.kind)
                            K_ADDR: begin
                                if (r_q.sr[7:1] == own_addr) begin
                                    r_d.ack  = 1'b1;
                                    r_d.rd   = r_q.sr[0];
                                    r_d.re   = r_q.sr[0];
                                    r_d.kind = K_REG;
                                end else if (r_q.sr == GC_ADDR) begin
                                    r_d.ack  = 1'b1;
                                    r_d.kind = K_GC;
                                end
                            end
                            K_GC: begin
                                if (r_q.sr == GC_RESET_CMD) begin
                                    r_d.ack = 1'b1;
                                    r_d.rst = 1'b1;
                                end
                            end
                            K_REG: begin
                                r_d.ack  = 1'b1;
                                r_d.ptr  = r_q.sr;
                                r_d.kind = K_DATA;
                            end
                            K_DATA: begin
                                r_d.ack   = 1'b1;
                                r_d.we    = 1'b1;
                                r_d.wdata = r_q.sr;
                            end
                            default: ;
                        endcase
                        r_d.sda_oe = r_d.ack;
                        r_d.scl_oe = r_d.ack & stretch_req;
                        r_d.state  = ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (r_q.ack && stretch_req) begin
                        r_d.scl_oe = 1'b1;
                    end else begin
                        r_d.scl_oe = 1'b0;
                        r_d.state  = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        r_d.cnt = '0;
                        if (!r_q.ack) begin
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_IDLE;
                        end else if (r_q.rd) begin
                            r_d.sda_oe = ~r_q.tx[7];
                            r_d.state  = ST_TX;
                        end else begin
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_MACK;
                        end else begin
                            r_d.tx     = {r_q.tx[BYTE_W-2:0], 1'b0};
                            r_d.cnt    = r_q.cnt + 1'b1;
                            r_d.sda_oe = ~r_q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) begin
                        if (!sda_f) begin
                            r_d.re    = 1'b1;
                            r_d.state = ST_MWAIT;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_MWAIT: begin
                    if (ev_fall) begin
                        r_d.cnt    = '0;
                        r_d.sda_oe = ~r_q.tx[7];
                        r_d.state  = ST_TX;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.kind  <= K_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe    = r_q.scl_oe;
    assign sda_oe    = r_q.sda_oe;
    assign reg_addr  = r_q.ptr;
    assign reg_wdata = r_q.wdata;
    assign reg_we    = r_q.we;
    assign reg_re    = r_q.re;
    assign bank_rst  = r_q.rst;
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [2:0] addr_sel,
    input logic       stretch_req,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       reg_re,
    input logic       bank_rst
);
    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);                                   // R6

    AST_STRETCH_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i);                                      // R5

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == $past(reg_addr) + 8'd1);                 // R2

    AST_PTR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> reg_addr == $past(reg_addr) + 8'd1);                 // R3

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rst |=> !bank_rst);                                        // R4

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, bank_rst}));                          // R10
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (.*);

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;
    localparam int H = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_oe, sda_oe;
    logic [2:0] addr_sel = 3'd0;
    logic       stretch_req = 1'b0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re, bank_rst;
    logic       scl_i, sda_i;

    int checks = 0, errors = 0;
    int we_cnt = 0, re_cnt = 0, rst_cnt = 0, oe_cyc = 0, sda_bad = 0;
    logic sda_oe_p = 1'b0;
    logic done = 1'b0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    assign scl_i = scl_m & ~scl_oe;
    assign sda_i = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twi_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_sel(addr_sel),
        .stretch_req(stretch_req), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re), .bank_rst(bank_rst)
    );

    always @(posedge clk) begin
        if (!rst_n || bank_rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
        if (rst_n) begin
            if (reg_we) we_cnt <= we_cnt + 1;
            if (reg_re) re_cnt <= re_cnt + 1;
            if (bank_rst) rst_cnt <= rst_cnt + 1;
            if (scl_oe) oe_cyc <= oe_cyc + 1;
            if (sda_oe != sda_oe_p && scl_i) sda_bad <= sda_bad + 1;
        end
        sda_oe_p <= sda_oe;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_write(input logic b, input logic glitch);
        sda_m = b;
        wait_cyc(H);
        scl_m = 1'b1;
        while (!scl_i) @(negedge clk);
        if (glitch) begin
            wait_cyc(H / 4);
            scl_m = 1'b0; wait_cyc(4); scl_m = 1'b1;
            wait_cyc(H / 4);
            sda_m = ~b; wait_cyc(4); sda_m = b;
            wait_cyc(H / 2 - 8);
        end else begin
            wait_cyc(H);
        end
        scl_m = 1'b0;
    endtask

    task automatic bit_read(output logic b);
        sda_m = 1'b1;
        wait_cyc(H);
        scl_m = 1'b1;
        while (!scl_i) @(negedge clk);
        wait_cyc(H / 2);
        b = sda_i;
        wait_cyc(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic wr_byte(input logic [7:0] v, input logic glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_write(v[i], glitch);
        bit_read(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_read(b);
            v[i] = b;
        end
        bit_write(~master_ack, 1'b0);
    endtask

    task automatic t_reset();
        chk("R9", "scl_oe", scl_oe, 0);
        chk("R9", "sda_oe", sda_oe, 0);
        chk("R9", "strobes", {reg_we, reg_re, bank_rst}, 0);
    endtask

    task automatic t_write();
        logic a;
        int w0 = we_cnt;
        do_start();
        wr_byte(8'h90, 0, a); chk("R1", "addr ack", a, 1);
        wr_byte(8'h52, 0, a); chk("R2", "reg ack", a, 1);
        wr_byte(8'h11, 0, a); chk("R2", "data0 ack", a, 1);
        wr_byte(8'h22, 0, a); chk("R2", "data1 ack", a, 1);
        do_stop();
        chk("R2", "mem52", mem[8'h52], 8'h11);
        chk("R2", "mem53 autoinc", mem[8'h53], 8'h22);
        chk("R2", "we pulses", we_cnt - w0, 2);
    endtask

    task automatic t_combined_read(input logic [7:0] ra, input logic [7:0] e0, input logic [7:0] e1);
        logic a;
        logic [7:0] v;
        int r0 = re_cnt;
        do_start();
        wr_byte(8'h90, 0, a);
        wr_byte(ra, 0, a);
        do_start();
        wr_byte(8'h91, 0, a); chk("R3", "read addr ack", a, 1);
        rd_byte(1'b1, v); chk("R3", "read byte0", v, e0);
        rd_byte(1'b0, v); chk("R3", "read byte1 autoinc", v, e1);
        chk("R3", "sda released after nack", sda_oe, 0);
        do_stop();
        chk("R3", "re pulses", re_cnt - r0, 2);
    endtask

    task automatic t_unmatched();
        logic a;
        int w0 = we_cnt, o0 = oe_cyc;
        stretch_req = 1'b1;
        do_start();
        wr_byte(8'h94, 0, a); chk("R1", "foreign addr nack", a, 0);
        wr_byte(8'h52, 0, a); chk("R1", "later byte nack", a, 0);
        wr_byte(8'hEE, 0, a); chk("R1", "data byte nack", a, 0);
        do_stop();
        stretch_req = 1'b0;
        chk("R1", "no write after foreign addr", we_cnt - w0, 0);
        chk("R5", "no stretch on nack", oe_cyc - o0, 0);
        chk("R1", "mem52 untouched", mem[8'h52], 8'h11);
    endtask

    task automatic t_addr_sel();
        logic a;
        addr_sel = 3'd5;
        do_start();
        wr_byte(8'h9A, 0, a); chk("R1", "sel5 ack", a, 1);
        wr_byte(8'h10, 0, a);
        wr_byte(8'h77, 0, a);
        do_stop();
        chk("R1", "sel5 write", mem[8'h10], 8'h77);
        do_start();
        wr_byte(8'h90, 0, a); chk("R1", "old addr nack", a, 0);
        do_stop();
        addr_sel = 3'd0;
    endtask

    task automatic t_general_call();
        logic a;
        int k0 = rst_cnt;
        do_start();
        wr_byte(8'h00, 0, a); chk("R4", "gc ack", a, 1);
        wr_byte(8'h04, 0, a); chk("R4", "other cmd nack", a, 0);
        do_stop();
        chk("R4", "no pulse for 0x04", rst_cnt - k0, 0);
        do_start();
        wr_byte(8'h00, 0, a);
        wr_byte(8'h06, 0, a); chk("R4", "reset cmd ack", a, 1);
        do_stop();
        chk("R4", "one reset pulse", rst_cnt - k0, 1);
        t_combined_read(8'h52, 8'h00, 8'h00);
    endtask

    task automatic t_stretch();
        logic a;
        stretch_req = 1'b1;
        do_start();
        for (int i = 7; i >= 0; i--) bit_write(8'h90 >> i, 1'b0);
        wait_cyc(H);
        chk("R5", "stretch asserted", scl_oe, 1);
        wait_cyc(100);
        chk("R5", "stretch held", scl_oe, 1);
        stretch_req = 1'b0;
        wait_cyc(5);
        chk("R5", "stretch released", scl_oe, 0);
        begin
            logic b;
            bit_read(b);
            chk("R5", "ack after stretch", b, 0);
        end
        wr_byte(8'h20, 0, a);
        wr_byte(8'h3C, 0, a);
        do_stop();
        chk("R5", "write after stretch", mem[8'h20], 8'h3C);
    endtask

    task automatic t_glitch();
        logic a;
        int w0 = we_cnt;
        do_start();
        wr_byte(8'h90, 1, a); chk("R7", "glitched addr ack", a, 1);
        wr_byte(8'h30, 1, a);
        wr_byte(8'hC3, 1, a); chk("R7", "glitched data ack", a, 1);
        do_stop();
        chk("R7", "glitched data value", mem[8'h30], 8'hC3);
        chk("R7", "one write", we_cnt - w0, 1);
    endtask

    task automatic t_abort();
        logic a;
        int w0 = we_cnt;
        do_start();
        wr_byte(8'h90, 0, a);
        wr_byte(8'h40, 0, a);
        for (int i = 0; i < 3; i++) bit_write(1'b1, 1'b0);
        do_stop();
        chk("R8", "partial byte no write", we_cnt - w0, 0);
        chk("R8", "idle after stop", {scl_oe, sda_oe}, 0);
        do_start();
        for (int i = 0; i < 4; i++) bit_write(1'b0, 1'b0);
        do_start();
        wr_byte(8'h90, 0, a); chk("R8", "restart addr ack", a, 1);
        wr_byte(8'h41, 0, a);
        wr_byte(8'h5D, 0, a);
        do_stop();
        chk("R8", "write after restart", mem[8'h41], 8'h5D);
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(20);
        t_reset();
        t_write();
        t_combined_read(8'h52, 8'h11, 8'h22);
        t_unmatched();
        t_addr_sel();
        t_stretch();
        t_glitch();
        t_abort();
        t_general_call();
        chk("R6", "sda changes while scl high", sda_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule